// File: doc/BRIEF.md
# Multichannel Cascaded Biquad Equalizer

This block equalizes a stream of audio samples belonging to several independent channels. Each accepted sample carries a channel number. It is scaled by a pre-gain stage, filtered by a programmable number of second-order recursive sections in series, and scaled again by a post-gain stage. Every stage multiplies at full precision and then applies its own arithmetic right shift, saturating the result to the signed sample range. The filtered sample leaves tagged with the same channel number.

All stages of all channels share one multiply-accumulate unit. Coefficients live outside the block in two flat per-channel lists, one of gains and one of shifts. The block drives the read addresses and uses the returned words in the same cycle. A sample is taken only when the block is idle. The run for that sample then takes a fixed number of cycles, set by the stage count. A mode input can make the block pass samples straight through while keeping the same timing.

Top module: `mbq_equalizer`

## Requirements
- R1: After reset, out_valid is low, in_ready is high, and the stored past inputs and past outputs of every section of every channel are zero.
- R2: in_ready is high only while the block is idle. A sample offered while in_ready is low is not taken. The sample on the inputs at a rising edge with in_valid and in_ready both high is taken.
- R3: For a sample taken at edge E, with N active sections, out_valid is high for exactly one cycle, starting at edge E+5N+2. This holds in both modes.
- R4: out_chan carries the channel number of the sample that produced the output.
- R5: The pre-gain and post-gain stages compute sat((v*g) >>> s) on the full 64-bit product. Gain address ch*(5*12+2)+0 holds the pre gain and ch*62+61 holds the post gain. Shift address ch*(12+2)+0 holds the pre shift and ch*14+13 holds the post shift. Shifts are 5-bit unsigned and the arithmetic shift rounds toward minus infinity.
- R6: Section b (0..11) of channel ch is Direct Form I. It reads coefficients c0..c4 at gain addresses ch*62+1+5b+0..4 and its shift at ch*14+1+b. Its result is sat((c0*x + c1*x[n-1] + c2*x[n-2] + c3*y[n-1] + c4*y[n-2]) >>> s), with the sum kept at full precision. The feedback sign is carried by c3 and c4.
- R7: Every stage result saturates to the range 0x80000000 to 0x7FFFFFFF.
- R8: cfg_stages_m1 gives the number of active sections minus one. Only sections 0..N-1 run, and values above 11 act as 11.
- R9: With cfg_active low, out_sample equals the input sample and no section history changes.
- R10: Each channel keeps its own section history. Samples of one channel do not affect the results of another.
- R11: cfg_active and cfg_stages_m1 are sampled at the edge that takes the sample. Changes while busy do not affect that sample.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_active | input | 1 | 1 = filter, 0 = pass-through |
| cfg_stages_m1 | input | 4 | Active section count minus one |
| in_valid | input | 1 | Sample offered |
| in_ready | output | 1 | Block idle, sample can be taken |
| in_chan | input | 3 | Channel of offered sample |
| in_sample | input | 32 | Offered sample, signed |
| gain_addr | output | 9 | Gain list read address |
| gain_data | input | 32 | Gain word at gain_addr, same cycle |
| shift_addr | output | 7 | Shift list read address |
| shift_data | input | 5 | Shift entry at shift_addr, same cycle |
| out_valid | output | 1 | Output sample valid pulse |
| out_chan | output | 3 | Channel of output sample |
| out_sample | output | 32 | Filtered sample, signed |

## Verification
A corrupted section history hides until the same channel is filtered again. The bench therefore revisits each channel many times and compares every output word with an independent model, so a wrong past value shows at that channel's next output. A sequencing fault such as a skipped term, a wrong section count or a wrong address moves the out_valid pulse or changes the word within one sample run. The bench checks in_ready and out_valid on every cycle, so a timing fault is caught in the cycle it occurs. Bypass and saturation runs confirm that history is frozen when required and that clamping happens at both ends of the range.

// File: rtl/mbq_pkg.sv
package mbq_pkg;
  // coefficient terms per section
  localparam int unsigned TAPS = 5;

  typedef enum logic [1:0] {
    SQ_IDLE = 2'd0,
    SQ_PRE  = 2'd1,
    SQ_BAND = 2'd2,
    SQ_POST = 2'd3
  } sq_state_e;
endpackage

// File: rtl/mbq_sequencer.sv
module mbq_sequencer
  import mbq_pkg::*;
#(
  parameter int unsigned CHANNELS = 8,
  parameter int unsigned BANDS    = 12,
  parameter int unsigned CHW      = 3,
  parameter int unsigned BW       = 4,
  parameter int unsigned GAW      = 9,
  parameter int unsigned SAW      = 7
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            in_valid,
  input  logic [CHW-1:0]  in_chan,
  input  logic            cfg_active,
  input  logic [BW-1:0]   cfg_stages_m1,
  output logic            in_ready,
  output logic            accept,
  output sq_state_e       state,
  output logic [CHW-1:0]  chan,
  output logic [BW-1:0]   band,
  output logic [2:0]      term,
  output logic            active,
  output logic            band_done,
  output logic [GAW-1:0]  gain_addr,
  output logic [SAW-1:0]  shift_addr
);
  localparam int unsigned GPC = BANDS * TAPS + 2;
  localparam int unsigned SPC = BANDS + 2;
  localparam logic [BW-1:0] LAST_BAND = BW'(BANDS - 1);
  localparam logic [2:0]    TERM_LAST = 3'(TAPS - 1);

  sq_state_e       state_q, state_d;
  logic [CHW-1:0]  chan_q, chan_d;
  logic [BW-1:0]   band_q, band_d;
  logic [2:0]      term_q, term_d;
  logic            act_q, act_d;
  logic [BW-1:0]   nb_q, nb_d;
  logic [GAW-1:0]  g_idx;
  logic [SAW-1:0]  s_idx;

  assign in_ready  = (state_q == SQ_IDLE);
  assign accept    = in_valid && in_ready;
  assign state     = state_q;
  assign chan      = chan_q;
  assign band      = band_q;
  assign term      = term_q;
  assign active    = act_q;
  assign band_done = (state_q == SQ_BAND) && (term_q == TERM_LAST);

  // next state
  always_comb begin
    state_d = state_q;
    chan_d  = chan_q;
    band_d  = band_q;
    term_d  = term_q;
    act_d   = act_q;
    nb_d    = nb_q;
    unique case (state_q)
      SQ_IDLE: begin
        if (in_valid) begin
          state_d = SQ_PRE;
          chan_d  = in_chan;
          act_d   = cfg_active;
          nb_d    = (cfg_stages_m1 > LAST_BAND) ? LAST_BAND : cfg_stages_m1;
        end
      end
      SQ_PRE: begin
        state_d = SQ_BAND;
        band_d  = '0;
        term_d  = '0;
      end
      SQ_BAND: begin
        if (term_q == TERM_LAST) begin
          term_d = '0;
          if (band_q == nb_q) state_d = SQ_POST;
          else                band_d  = band_q + 1'b1;
        end else begin
          term_d = term_q + 1'b1;
        end
      end
      SQ_POST: state_d = SQ_IDLE;
      default: state_d = SQ_IDLE;
    endcase
  end

  // coefficient addressing inside the channel region
  always_comb begin
    g_idx = '0;
    s_idx = '0;
    unique case (state_q)
      SQ_BAND: begin
        g_idx = GAW'(1) + GAW'(band_q) * GAW'(TAPS) + GAW'(term_q);
        s_idx = SAW'(1) + SAW'(band_q);
      end
      SQ_POST: begin
        g_idx = GAW'(GPC - 1);
        s_idx = SAW'(SPC - 1);
      end
      default: begin
        g_idx = '0;
        s_idx = '0;
      end
    endcase
  end

  assign gain_addr  = GAW'(chan_q) * GAW'(GPC) + g_idx;
  assign shift_addr = SAW'(chan_q) * SAW'(SPC) + s_idx;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= SQ_IDLE;
      chan_q  <= '0;
      band_q  <= '0;
      term_q  <= '0;
      act_q   <= 1'b0;
      nb_q    <= '0;
    end else begin
      state_q <= state_d;
      chan_q  <= chan_d;
      band_q  <= band_d;
      term_q  <= term_d;
      act_q   <= act_d;
      nb_q    <= nb_d;
    end
  end

  a_r2_busy_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> !in_ready);

  a_r8_band_within_count: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == SQ_BAND) |-> (band_q <= nb_q));

  a_r4_chan_held: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q != SQ_IDLE) |=> $stable(chan_q));
endmodule

// File: rtl/mbq_mac.sv
module mbq_mac #(
  parameter int unsigned DW   = 32,
  parameter int unsigned SHW  = 5,
  parameter int unsigned ACCW = 68
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           clr,
  input  logic           en,
  input  logic [DW-1:0]  op,
  input  logic [DW-1:0]  coef,
  input  logic [SHW-1:0] shamt,
  output logic [DW-1:0]  result
);
  localparam logic signed [ACCW-1:0] ACC_ZERO = '0;
  localparam logic [DW-1:0] POS_LIM = {1'b0, {(DW-1){1'b1}}};
  localparam logic [DW-1:0] NEG_LIM = {1'b1, {(DW-1){1'b0}}};

  logic signed [2*DW-1:0] prod;
  logic signed [ACCW-1:0] prod_ext, acc_base, acc_d, acc_q, shifted;
  logic [ACCW-DW:0]       upper;

  assign prod     = $signed(op) * $signed(coef);
  assign prod_ext = $signed({{(ACCW-2*DW){prod[2*DW-1]}}, prod});
  assign acc_base = clr ? ACC_ZERO : acc_q;
  assign acc_d    = acc_base + prod_ext;
  assign shifted  = acc_d >>> shamt;
  assign upper    = shifted[ACCW-1:DW-1];

  // clamp to the sample range
  always_comb begin
    if ((&upper) || !(|upper)) result = shifted[DW-1:0];
    else if (shifted[ACCW-1])  result = NEG_LIM;
    else                       result = POS_LIM;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  acc_q <= ACC_ZERO;
    else if (en) acc_q <= acc_d;
  end
endmodule

// File: rtl/mbq_history.sv
module mbq_history #(
  parameter int unsigned CHANNELS = 8,
  parameter int unsigned BANDS    = 12,
  parameter int unsigned DW       = 32,
  parameter int unsigned CHW      = 3,
  parameter int unsigned BW       = 4
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           we,
  input  logic [CHW-1:0] chan,
  input  logic [BW-1:0]  band,
  input  logic [2:0]     term,
  input  logic [DW-1:0]  new_x,
  input  logic [DW-1:0]  new_y,
  output logic [DW-1:0]  rd
);
  logic [DW-1:0] ch_rd [CHANNELS];

  for (genvar c = 0; c < CHANNELS; c++) begin : g_ch
    logic [DW-1:0] x1_q [BANDS];
    logic [DW-1:0] x2_q [BANDS];
    logic [DW-1:0] y1_q [BANDS];
    logic [DW-1:0] y2_q [BANDS];
    logic          hit;
    logic [DW-1:0] sel;

    assign hit = we && (chan == CHW'(c));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        for (int b = 0; b < BANDS; b++) begin
          x1_q[b] <= '0;
          x2_q[b] <= '0;
          y1_q[b] <= '0;
          y2_q[b] <= '0;
        end
      end else if (hit) begin
        x2_q[band] <= x1_q[band];
        x1_q[band] <= new_x;
        y2_q[band] <= y1_q[band];
        y1_q[band] <= new_y;
      end
    end

    // term 1..4 selects x[n-1], x[n-2], y[n-1], y[n-2]
    always_comb begin
      unique case (term)
        3'd1:    sel = x1_q[band];
        3'd2:    sel = x2_q[band];
        3'd3:    sel = y1_q[band];
        3'd4:    sel = y2_q[band];
        default: sel = '0;
      endcase
    end

    assign ch_rd[c] = sel;
  end

  assign rd = ch_rd[chan];
endmodule

// File: rtl/mbq_equalizer.sv
module mbq_equalizer
  import mbq_pkg::*;
#(
  parameter int unsigned CHANNELS = 8,
  parameter int unsigned BANDS    = 12,
  parameter int unsigned DW       = 32,
  parameter int unsigned SHW      = 5,
  localparam int unsigned CHW  = $clog2(CHANNELS),
  localparam int unsigned BW   = $clog2(BANDS),
  localparam int unsigned GPC  = BANDS * TAPS + 2,
  localparam int unsigned SPC  = BANDS + 2,
  localparam int unsigned GAW  = $clog2(CHANNELS * GPC),
  localparam int unsigned SAW  = $clog2(CHANNELS * SPC),
  localparam int unsigned ACCW = 2 * DW + $clog2(TAPS) + 1
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           cfg_active,
  input  logic [BW-1:0]  cfg_stages_m1,
  input  logic           in_valid,
  output logic           in_ready,
  input  logic [CHW-1:0] in_chan,
  input  logic [DW-1:0]  in_sample,
  output logic [GAW-1:0] gain_addr,
  input  logic [DW-1:0]  gain_data,
  output logic [SAW-1:0] shift_addr,
  input  logic [SHW-1:0] shift_data,
  output logic           out_valid,
  output logic [CHW-1:0] out_chan,
  output logic [DW-1:0]  out_sample
);
  sq_state_e      st;
  logic           accept, act, band_done;
  logic [CHW-1:0] chan;
  logic [BW-1:0]  band;
  logic [2:0]     term;
  logic           mac_clr, mac_en, hist_we;
  logic [DW-1:0]  operand, mac_res, hist_rd;
  logic [DW-1:0]  cur_q, cur_d, raw_q, raw_d;
  logic           ov_q, ov_d;
  logic [CHW-1:0] oc_q, oc_d;
  logic [DW-1:0]  os_q, os_d;

  mbq_sequencer #(
    .CHANNELS(CHANNELS), .BANDS(BANDS), .CHW(CHW), .BW(BW), .GAW(GAW), .SAW(SAW)
  ) u_seq (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_chan(in_chan),
    .cfg_active(cfg_active), .cfg_stages_m1(cfg_stages_m1),
    .in_ready(in_ready), .accept(accept), .state(st), .chan(chan),
    .band(band), .term(term), .active(act), .band_done(band_done),
    .gain_addr(gain_addr), .shift_addr(shift_addr)
  );

  assign mac_clr = (st == SQ_PRE) || (st == SQ_POST) || ((st == SQ_BAND) && (term == 3'd0));
  assign mac_en  = (st != SQ_IDLE);
  assign operand = ((st == SQ_BAND) && (term != 3'd0)) ? hist_rd : cur_q;
  assign hist_we = band_done && act;

  mbq_mac #(.DW(DW), .SHW(SHW), .ACCW(ACCW)) u_mac (
    .clk(clk), .rst_n(rst_n), .clr(mac_clr), .en(mac_en),
    .op(operand), .coef(gain_data), .shamt(shift_data), .result(mac_res)
  );

  mbq_history #(
    .CHANNELS(CHANNELS), .BANDS(BANDS), .DW(DW), .CHW(CHW), .BW(BW)
  ) u_hist (
    .clk(clk), .rst_n(rst_n), .we(hist_we), .chan(chan), .band(band),
    .term(term), .new_x(cur_q), .new_y(mac_res), .rd(hist_rd)
  );

  // next state of the running value and the output stage
  always_comb begin
    cur_d = cur_q;
    raw_d = raw_q;
    if (accept) begin
      cur_d = in_sample;
      raw_d = in_sample;
    end else if ((st == SQ_PRE) || band_done) begin
      cur_d = mac_res;
    end
    ov_d = (st == SQ_POST);
    oc_d = oc_q;
    os_d = os_q;
    if (st == SQ_POST) begin
      oc_d = chan;
      os_d = act ? mac_res : raw_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur_q <= '0;
      raw_q <= '0;
      ov_q  <= 1'b0;
      oc_q  <= '0;
      os_q  <= '0;
    end else begin
      cur_q <= cur_d;
      raw_q <= raw_d;
      ov_q  <= ov_d;
      oc_q  <= oc_d;
      os_q  <= os_d;
    end
  end

  assign out_valid  = ov_q;
  assign out_chan   = oc_q;
  assign out_sample = os_q;

  a_r3_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |=> !out_valid);

  a_r3_idle_at_output: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> in_ready);
endmodule

// File: tb/sim_mbq_equalizer.sv
module sim_mbq_equalizer;
  localparam int NCH = 8;
  localparam int NB  = 12;
  localparam int GPC = NB * 5 + 2;
  localparam int SPC = NB + 2;
  localparam logic signed [71:0] MAXV = 72'sd2147483647;
  localparam logic signed [71:0] MINV = -72'sd2147483648;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic        rst_n, cfg_active, in_valid, in_ready, out_valid;
  logic [3:0]  cfg_stages_m1;
  logic [2:0]  in_chan, out_chan;
  logic [31:0] in_sample, gain_data, out_sample;
  logic [8:0]  gain_addr;
  logic [6:0]  shift_addr;
  logic [4:0]  shift_data;

  logic [31:0] gmem [NCH*GPC];
  logic [4:0]  smem [NCH*SPC];

  assign gain_data  = (int'(gain_addr) < NCH*GPC) ? gmem[gain_addr] : '0;
  assign shift_data = (int'(shift_addr) < NCH*SPC) ? smem[shift_addr] : '0;

  mbq_equalizer u0 (
    .clk(clk), .rst_n(rst_n), .cfg_active(cfg_active), .cfg_stages_m1(cfg_stages_m1),
    .in_valid(in_valid), .in_ready(in_ready), .in_chan(in_chan), .in_sample(in_sample),
    .gain_addr(gain_addr), .gain_data(gain_data), .shift_addr(shift_addr),
    .shift_data(shift_data), .out_valid(out_valid), .out_chan(out_chan),
    .out_sample(out_sample)
  );

  // reference state
  logic signed [31:0] hx1 [NCH][NB];
  logic signed [31:0] hx2 [NCH][NB];
  logic signed [31:0] hy1 [NCH][NB];
  logic signed [31:0] hy2 [NCH][NB];

  int n_cmp = 0, n_bad = 0, cyc = 0, due = 0, seed = 12345;
  bit pend = 0, acc_flag = 0, acc_act = 0, done = 0;
  int acc_n = 1;
  logic [2:0]  acc_ch, exp_chan;
  logic [31:0] acc_s, exp_val;
  string req_tag = "R1";

  always @(posedge clk) cyc <= cyc + 1;

  function automatic logic signed [71:0] mul(logic signed [31:0] a, logic signed [31:0] b);
    logic signed [71:0] ea, eb;
    ea = a;
    eb = b;
    return ea * eb;
  endfunction

  function automatic logic [31:0] sat32(logic signed [71:0] v);
    if (v > MAXV) return 32'h7FFFFFFF;
    if (v < MINV) return 32'h80000000;
    return v[31:0];
  endfunction

  function automatic logic [31:0] scale(logic [31:0] x, logic [31:0] g, logic [4:0] s);
    return sat32(mul(x, g) >>> s);
  endfunction

  // behavioural equalizer: pre stage, nb sections, post stage
  function automatic logic [31:0] model_run(logic [2:0] ch, logic [31:0] x, bit act, int nb);
    logic signed [31:0] v, r;
    logic signed [71:0] acc;
    int c;
    c = int'(ch);
    if (!act) return x;
    v = scale(x, gmem[c*GPC], smem[c*SPC]);
    for (int b = 0; b < nb; b++) begin
      int base;
      base = c*GPC + 1 + b*5;
      acc = mul(v, gmem[base]) + mul(hx1[c][b], gmem[base+1]) + mul(hx2[c][b], gmem[base+2])
          + mul(hy1[c][b], gmem[base+3]) + mul(hy2[c][b], gmem[base+4]);
      r = sat32(acc >>> smem[c*SPC + 1 + b]);
      hx2[c][b] = hx1[c][b];
      hx1[c][b] = v;
      hy2[c][b] = hy1[c][b];
      hy1[c][b] = r;
      v = r;
    end
    return scale(v, gmem[c*GPC + GPC - 1], smem[c*SPC + SPC - 1]);
  endfunction

  task automatic check_bit(string tag, logic act, logic exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s cycle %0d: got %0b expected %0b", tag, cyc, act, exp);
    end
  endtask

  task automatic check_word(string tag, logic [31:0] act, logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s cycle %0d: got %h expected %h", tag, cyc, act, exp);
    end
  endtask

  // one clock: reference update at the negative edge, then compare
  task automatic tick();
    bit rdy_exp, val_exp;
    @(negedge clk);
    if (acc_flag) begin
      exp_val  = model_run(acc_ch, acc_s, acc_act, acc_n);
      exp_chan = acc_ch;
      due      = cyc + 5*acc_n + 2;   // R3 latency
      pend     = 1;
      acc_flag = 0;
    end
    rdy_exp = !(pend && cyc < due);
    val_exp = pend && (cyc == due);
    check_bit("R2", in_ready, rdy_exp);
    check_bit("R3", out_valid, val_exp);
    if (val_exp) begin
      if (out_valid) begin
        check_word("R4", {29'd0, out_chan}, {29'd0, exp_chan});
        check_word(req_tag, out_sample, exp_val);
      end
      pend = 0;
    end
  endtask

  task automatic drive(bit v, logic [2:0] ch, logic [31:0] s);
    in_valid  = v;
    in_chan   = ch;
    in_sample = s;
    if (v && !(pend && cyc < due)) begin
      acc_flag = 1;
      acc_ch   = ch;
      acc_s    = s;
      acc_act  = cfg_active;                                   // R11 snapshot
      acc_n    = ((cfg_stages_m1 > 4'd11) ? 11 : int'(cfg_stages_m1)) + 1;  // R8
    end
  endtask

  task automatic send(logic [2:0] ch, logic [31:0] s);
    while (pend) tick();
    drive(1'b1, ch, s);
    tick();
    drive(1'b0, ch, 32'd0);
  endtask

  task automatic drain();
    while (pend || acc_flag) tick();
    tick();
  endtask

  function automatic logic [31:0] rnd();
    seed = seed * 1103515245 + 12345;
    return 32'($signed(seed) >>> 3);
  endfunction

  task automatic load_filters();
    for (int c = 0; c < NCH; c++) begin
      gmem[c*GPC]           = 32'd8388608;
      smem[c*SPC]           = 5'd23;
      gmem[c*GPC + GPC - 1] = 32'd268435456;
      smem[c*SPC + SPC - 1] = 5'd28;
      for (int b = 0; b < NB; b++) begin
        int base;
        base = c*GPC + 1 + b*5;
        gmem[base]   = 32'h20000000 + 32'(b << 22) + 32'(c << 20);
        gmem[base+1] = 32'h10000000;
        gmem[base+2] = -32'sd134217728;
        gmem[base+3] = 32'h20000000;
        gmem[base+4] = -32'sd268435456;
        smem[c*SPC + 1 + b] = 5'd30;
      end
    end
  endtask

  task automatic load_identity(int c, logic [31:0] pg, logic [4:0] ps, logic [31:0] qg, logic [4:0] qs);
    gmem[c*GPC]           = pg;
    smem[c*SPC]           = ps;
    gmem[c*GPC + GPC - 1] = qg;
    smem[c*SPC + SPC - 1] = qs;
    for (int b = 0; b < NB; b++) begin
      int base;
      base = c*GPC + 1 + b*5;
      gmem[base]   = 32'd1;
      gmem[base+1] = 32'd0;
      gmem[base+2] = 32'd0;
      gmem[base+3] = 32'd0;
      gmem[base+4] = 32'd0;
      smem[c*SPC + 1 + b] = 5'd0;
    end
  endtask

  initial begin
    for (int c = 0; c < NCH; c++)
      for (int b = 0; b < NB; b++) begin
        hx1[c][b] = '0; hx2[c][b] = '0; hy1[c][b] = '0; hy2[c][b] = '0;
      end
    load_filters();
    rst_n = 1'b0; cfg_active = 1'b1; cfg_stages_m1 = 4'd4;
    in_valid = 1'b0; in_chan = '0; in_sample = '0;

    // R1: idle outputs while in reset
    repeat (3) begin
      @(negedge clk);
      check_bit("R1", in_ready, 1'b1);
      check_bit("R1", out_valid, 1'b0);
    end
    rst_n = 1'b1;
    tick();

    // R1: first sample sees cleared history
    req_tag = "R1";
    send(3'd0, 32'h00100000);
    drain();

    // R6: full filtering across all channels
    req_tag = "R6";
    for (int i = 0; i < 24; i++) send(3'(i % 8), rnd());

    // R10: one channel hammered, others must stay independent
    req_tag = "R10";
    for (int i = 0; i < 8; i++) send(3'd3, rnd());
    send(3'd5, rnd());
    send(3'd4, rnd());

    // R8: section counts, including clamp above 11
    req_tag = "R8";
    drain(); cfg_stages_m1 = 4'd0;
    for (int i = 0; i < 4; i++) send(3'(i), rnd());
    drain(); cfg_stages_m1 = 4'd11;
    for (int i = 0; i < 3; i++) send(3'(i + 1), rnd());
    drain(); cfg_stages_m1 = 4'd15;
    for (int i = 0; i < 3; i++) send(3'(i + 2), rnd());

    // R9: bypass keeps data and freezes history (R3 timing unchanged)
    req_tag = "R9";
    drain(); cfg_stages_m1 = 4'd4; cfg_active = 1'b0;
    for (int i = 0; i < 4; i++) send(3'd2, rnd());
    drain(); cfg_active = 1'b1;
    for (int i = 0; i < 3; i++) send(3'd2, rnd());

    // R11: configuration change while busy has no effect on that sample
    req_tag = "R11";
    drain(); cfg_stages_m1 = 4'd2;
    send(3'd1, rnd());
    cfg_stages_m1 = 4'd9; cfg_active = 1'b0;
    tick(); tick();
    drain(); cfg_active = 1'b1; cfg_stages_m1 = 4'd5;
    send(3'd1, rnd());

    // R7: saturation at both ends
    req_tag = "R7";
    drain();
    load_identity(7, 32'h7FFFFFFF, 5'd0, 32'd1, 5'd0);
    send(3'd7, 32'h7FFFFFFF);
    send(3'd7, 32'h80000000);
    send(3'd7, 32'hFFFFFFFF);
    send(3'd7, 32'd0);
    send(3'd7, 32'd1);

    // R5: pre and post scaling with negative rounding
    req_tag = "R5";
    drain();
    load_identity(6, 32'd3, 5'd1, -32'sd5, 5'd2);
    send(3'd6, 32'd7);
    send(3'd6, -32'sd9);
    send(3'd6, 32'h12345678);
    send(3'd6, rnd());

    // R2: in_valid held high while busy, offered data changing every cycle
    req_tag = "R2";
    drain(); cfg_stages_m1 = 4'd1;
    for (int k = 0; k < 300; k++) begin
      drive(1'b1, 3'(k % 8), rnd());
      tick();
    end
    drive(1'b0, 3'd0, 32'd0);
    drain();

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    #(20 * 150000);
    if (!done) begin
      n_bad++;
      $display("FAIL R3 watchdog: got no completion expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule